// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the singly linked chain of extended capability headers stored in a 4 KB configuration RAM. The chain always starts at byte offset 256. Each 32-bit header carries a capability ID, a version and a pointer to the next header. The block has two commands.

A find command takes an ID and follows the pointers from the chain head. It returns the byte offset of the first header with that ID, or 0 when no header has it. It also returns the offset of the header visited just before the one it stopped on. An append command places a new header at a caller-given offset and links it into the chain.

The block reaches the RAM through a single-port 32-bit word interface with a one-cycle read latency, and uses it for one access per cycle. A pointer that is damaged or runs in a loop ends the command with an error flag, so the walk never hangs.

Top module: `capChainWalker`

## Requirements
- R1: After reset, `busy`, `done`, `resError`, `resOffset`, `resPrev` and `ramEn` are all 0, and no RAM access is made until a command is accepted.
- R2: A find on a chain whose word at byte offset 256 is all zero reports offset 0 and previous 0, after exactly one header read.
- R3: Headers use this layout: ID in bits 15:0, version in bits 19:16, next byte offset in bits 31:20. A find reports the offset of the first header whose ID matches. It reports the previous header's offset as the previous value, which is 0 when the match is at 256.
- R4: A next field of 0 ends the chain. A find that reaches the end without a match reports offset 0 and reports the last header's offset as the previous value.
- R5: A find for the reserved ID 0 on a non-empty chain in which no header has ID 0 reports offset 0 and the tail header's offset as the previous value.
- R6: A next pointer that is not a multiple of 4, is below 256 or is above 4088 is never read. The command ends with `resError`=1 and both offsets 0.
- R7: A walk reads at most MAX_VISITS (default 960) headers. A cyclic chain ends in an error after exactly MAX_VISITS reads.
- R8: An append at offset 256 reads that header once. It then writes one word {old next, new version, new ID} back to 256, and reports offset 256 with previous 0.
- R9: An append at any other offset walks to the tail. It rewrites the tail header with its next field set to the new offset and bits 19:0 kept. It then writes {0, version, ID} at the new offset, and reports the new offset with the tail as the previous value.
- R10: An append is rejected with `resError`=1 and makes no RAM access if the offset is not 4-byte aligned, the offset is below 256, the size is below 8, or offset+size is 4096 or more. An append to an empty chain at an offset other than 256 is rejected after one read and makes no write.
- R11: `done` is high for exactly one cycle per accepted command. `busy` is high from the cycle after acceptance through the `done` cycle. `cmdValid` is ignored while `busy` is high.
- R12: The RAM sees at most one access per cycle. A command makes exactly one read for each header it visits, and read data is used the cycle after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, accepted when idle |
| cmdAppend | input | 1 | 1 = append, 0 = find |
| cmdId | input | 16 | Capability ID to find or to append |
| cmdVer | input | 4 | Version of the appended header |
| cmdOffset | input | 12 | Byte offset of the appended header |
| cmdSize | input | 13 | Byte size of the appended capability |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| resOffset | output | 12 | Matching or appended header offset, 0 if none |
| resPrev | output | 12 | Offset of the preceding header |
| resError | output | 1 | Bad argument, bad pointer or walk limit |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 10 | RAM word address |
| ramWdata | output | 32 | RAM write data |
| ramRdata | input | 32 | RAM read data, valid one cycle after a read |

## Verification
The hardest case to reach from the ports is the visit limit. Only a chain that points back into itself can run that long, and every well-formed chain ends within a few headers. The bench preloads the RAM model with a header at 256 whose next field is 256. It then searches for an absent ID and counts the reads issued before the error. The tail patch in an append is also checked word by word against the RAM model, which confirms that the kept low bits and the new pointer land in the right header.

// File: rtl/capChainPkg.sv
package capChainPkg;

  localparam int OFF_W   = 12;
  localparam int ID_W    = 16;
  localparam int VER_W   = 4;
  localparam int HDR_W   = OFF_W + VER_W + ID_W;
  localparam int WORD_AW = OFF_W - 2;
  localparam int SIZE_W  = OFF_W + 1;
  localparam int LAST_HDR_OFF = (1 << OFF_W) - 8;

  typedef struct packed {
    logic [OFF_W-1:0] next;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } capHdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRTAIL,
    ST_WRNEW,
    ST_DONE
  } walkState_e;

  typedef struct packed {
    logic loadCmd;
    logic rdHdr;
    logic step;
    logic latchHdr;
    logic wrTail;
    logic wrNew;
    logic resHit;
    logic resEnd;
    logic resEmpty;
    logic resAppend;
    logic resErr;
  } walkStrobe_t;

  typedef struct packed {
    logic isAppend;
    logic argBad;
    logic atBase;
    logic firstVisit;
    logic hdrZero;
    logic idMatch;
    logic nextZero;
    logic nextBad;
    logic limitHit;
  } walkStatus_t;

endpackage

// File: rtl/capChainCtrl.sv
module capChainCtrl
  import capChainPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdAppend,
  input  walkStatus_t st,
  output walkStrobe_t sb,
  output logic        busy,
  output logic        done
);

  walkState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    sb = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          sb.loadCmd = 1'b1;
          if (cmdAppend && st.argBad) begin
            sb.resErr = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_READ;
          end
        end
      end
      ST_READ: begin
        sb.rdHdr = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (st.isAppend && st.atBase) begin
          sb.latchHdr  = 1'b1;
          sb.resAppend = 1'b1;
          stateNext    = ST_WRNEW;
        end else if (st.firstVisit && st.hdrZero) begin
          if (st.isAppend) sb.resErr = 1'b1;
          else             sb.resEmpty = 1'b1;
          stateNext = ST_DONE;
        end else if (st.idMatch) begin
          if (st.isAppend) sb.resErr = 1'b1;
          else             sb.resHit = 1'b1;
          stateNext = ST_DONE;
        end else if (st.nextZero) begin
          if (st.isAppend) begin
            sb.latchHdr  = 1'b1;
            sb.resAppend = 1'b1;
            stateNext    = ST_WRTAIL;
          end else begin
            sb.resEnd = 1'b1;
            stateNext = ST_DONE;
          end
        end else if (st.nextBad || st.limitHit) begin
          sb.resErr = 1'b1;
          stateNext = ST_DONE;
        end else begin
          sb.step   = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_WRTAIL: begin
        sb.wrTail = 1'b1;
        stateNext = ST_WRNEW;
      end
      ST_WRNEW: begin
        sb.wrNew  = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_tail_then_new_R9: assert property (@(posedge clk) disable iff (!rstN)
    sb.wrTail |=> sb.wrNew);

  assert_single_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sb.rdHdr, sb.wrTail, sb.wrNew}));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(sb.rdHdr || sb.wrTail || sb.wrNew));

  assert_read_then_wait_R12: assert property (@(posedge clk) disable iff (!rstN)
    sb.rdHdr |=> (busy && !sb.rdHdr && !done));

endmodule

// File: rtl/capChainPath.sv
module capChainPath
  import capChainPkg::*;
#(
  parameter int LIST_BASE  = 256,
  parameter int MAX_VISITS = 960
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        sb,
  input  logic               cmdAppend,
  input  logic [ID_W-1:0]    cmdId,
  input  logic [VER_W-1:0]   cmdVer,
  input  logic [OFF_W-1:0]   cmdOffset,
  input  logic [SIZE_W-1:0]  cmdSize,
  input  logic [HDR_W-1:0]   ramRdata,
  output walkStatus_t        st,
  output logic               ramEn,
  output logic               ramWe,
  output logic [WORD_AW-1:0] ramAddr,
  output logic [HDR_W-1:0]   ramWdata,
  output logic [OFF_W-1:0]   resOffset,
  output logic [OFF_W-1:0]   resPrev,
  output logic               resError
);

  localparam int CNT_W = $clog2(MAX_VISITS + 1);
  localparam logic [OFF_W-1:0]   BASE_OFF  = OFF_W'(LIST_BASE);
  localparam logic [OFF_W-1:0]   LAST_OFF  = OFF_W'(LAST_HDR_OFF);
  localparam logic [WORD_AW-1:0] BASE_WORD = BASE_OFF[OFF_W-1:2];
  localparam logic [WORD_AW-1:0] LAST_WORD = LAST_OFF[OFF_W-1:2];
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(MAX_VISITS - 1);
  localparam logic [SIZE_W-1:0]  MIN_SIZE  = SIZE_W'(8);
  localparam logic [SIZE_W:0]    SPACE_END = (SIZE_W+1)'(1 << OFF_W);

  logic               opAppend;
  logic [ID_W-1:0]    idReg;
  logic [VER_W-1:0]   verReg;
  logic [OFF_W-1:0]   newOff;
  logic [OFF_W-1:0]   curOff;
  logic [OFF_W-1:0]   prevOff;
  logic [CNT_W-1:0]   visitCnt;
  capHdr_t            hdrKeep;
  capHdr_t            hdrIn;
  logic [ID_W-1:0]    searchId;
  logic [SIZE_W:0]    endSum;
  logic               atBase;

  assign hdrIn    = capHdr_t'(ramRdata);
  assign searchId = opAppend ? '0 : idReg;
  assign endSum   = {2'b00, cmdOffset} + {1'b0, cmdSize};
  assign atBase   = (newOff == BASE_OFF);

  // status towards the controller
  always_comb begin
    st.isAppend   = opAppend;
    st.argBad     = (cmdOffset[1:0] != 2'b00) || (cmdOffset < BASE_OFF) ||
                    (cmdSize < MIN_SIZE) || (endSum >= SPACE_END);
    st.atBase     = atBase;
    st.firstVisit = (visitCnt == '0);
    st.hdrZero    = (ramRdata == '0);
    st.idMatch    = (hdrIn.id == searchId);
    st.nextZero   = (hdrIn.next == '0);
    st.nextBad    = (hdrIn.next[1:0] != 2'b00) || (hdrIn.next < BASE_OFF) ||
                    (hdrIn.next > LAST_OFF);
    st.limitHit   = (visitCnt == CNT_LAST);
  end

  // command and walk registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAppend <= 1'b0;
      idReg    <= '0;
      verReg   <= '0;
      newOff   <= '0;
      curOff   <= '0;
      prevOff  <= '0;
      visitCnt <= '0;
      hdrKeep  <= '0;
    end else begin
      if (sb.loadCmd) begin
        opAppend <= cmdAppend;
        idReg    <= cmdId;
        verReg   <= cmdVer;
        newOff   <= cmdOffset;
        curOff   <= BASE_OFF;
        prevOff  <= '0;
        visitCnt <= '0;
      end else if (sb.step) begin
        prevOff  <= curOff;
        curOff   <= hdrIn.next;
        visitCnt <= visitCnt + 1'b1;
      end
      if (sb.latchHdr) hdrKeep <= hdrIn;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOffset <= '0;
      resPrev   <= '0;
      resError  <= 1'b0;
    end else if (sb.resHit) begin
      resOffset <= curOff;
      resPrev   <= prevOff;
      resError  <= 1'b0;
    end else if (sb.resEnd) begin
      resOffset <= '0;
      resPrev   <= curOff;
      resError  <= 1'b0;
    end else if (sb.resAppend) begin
      resOffset <= newOff;
      resPrev   <= atBase ? '0 : curOff;
      resError  <= 1'b0;
    end else if (sb.resEmpty || sb.resErr) begin
      resOffset <= '0;
      resPrev   <= '0;
      resError  <= sb.resErr;
    end
  end

  // RAM port
  assign ramEn   = sb.rdHdr | sb.wrTail | sb.wrNew;
  assign ramWe   = sb.wrTail | sb.wrNew;
  assign ramAddr = sb.wrNew ? newOff[OFF_W-1:2] : curOff[OFF_W-1:2];

  always_comb begin
    if (sb.wrTail) ramWdata = {newOff, hdrKeep.ver, hdrKeep.id};
    else           ramWdata = {(atBase ? hdrKeep.next : {OFF_W{1'b0}}), verReg, idReg};
  end

  assert_read_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && !ramWe) |-> (ramAddr >= BASE_WORD && ramAddr <= LAST_WORD));

  assert_visit_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    visitCnt <= CNT_LAST);

  assert_error_clears_offsets_R6: assert property (@(posedge clk) disable iff (!rstN)
    resError |-> (resOffset == '0 && resPrev == '0));

  assert_hit_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resOffset != '0) |-> (resOffset[1:0] == 2'b00 && resOffset >= BASE_OFF));

  assert_write_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && ramWe) |-> (ramAddr >= BASE_WORD));

endmodule

// File: rtl/capChainWalker.sv
module capChainWalker
  import capChainPkg::*;
#(
  parameter int LIST_BASE  = 256,
  parameter int MAX_VISITS = 960
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdAppend,
  input  logic [15:0] cmdId,
  input  logic [3:0]  cmdVer,
  input  logic [11:0] cmdOffset,
  input  logic [12:0] cmdSize,
  output logic        busy,
  output logic        done,
  output logic [11:0] resOffset,
  output logic [11:0] resPrev,
  output logic        resError,
  output logic        ramEn,
  output logic        ramWe,
  output logic [9:0]  ramAddr,
  output logic [31:0] ramWdata,
  input  logic [31:0] ramRdata
);

  walkStrobe_t strobes;
  walkStatus_t status;

  capChainCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdAppend (cmdAppend),
    .st        (status),
    .sb        (strobes),
    .busy      (busy),
    .done      (done)
  );

  capChainPath #(
    .LIST_BASE  (LIST_BASE),
    .MAX_VISITS (MAX_VISITS)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .sb        (strobes),
    .cmdAppend (cmdAppend),
    .cmdId     (cmdId),
    .cmdVer    (cmdVer),
    .cmdOffset (cmdOffset),
    .cmdSize   (cmdSize),
    .ramRdata  (ramRdata),
    .st        (status),
    .ramEn     (ramEn),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata),
    .resOffset (resOffset),
    .resPrev   (resPrev),
    .resError  (resError)
  );

endmodule

// File: tb/capChainWalker_tb_top.sv
module capChainWalker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdAppend = 1'b0;
  logic [15:0] cmdId = '0;
  logic [3:0]  cmdVer = '0;
  logic [11:0] cmdOffset = '0;
  logic [12:0] cmdSize = '0;
  logic        busy, done, resError, ramEn, ramWe;
  logic [11:0] resOffset, resPrev;
  logic [9:0]  ramAddr;
  logic [31:0] ramWdata;
  logic [31:0] ramRdata = '0;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  capChainWalker dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAppend(cmdAppend),
    .cmdId(cmdId), .cmdVer(cmdVer), .cmdOffset(cmdOffset), .cmdSize(cmdSize),
    .busy(busy), .done(done), .resOffset(resOffset), .resPrev(resPrev),
    .resError(resError), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // RAM model with a backdoor port for the bench
  logic [31:0] mem [1024];
  logic        bdWe = 1'b0;
  logic        bdClr = 1'b0;
  logic [9:0]  bdAddr = '0;
  logic [31:0] bdData = '0;
  int rdCount = 0;
  int wrCount = 0;
  int accInCycle = 0;

  always @(posedge clk) begin
    if (bdClr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (bdWe) begin
      mem[bdAddr] <= bdData;
    end
    if (ramEn) begin
      if (ramWe) begin
        mem[ramAddr] <= ramWdata;
        wrCount <= wrCount + 1;
      end else begin
        ramRdata <= mem[ramAddr];
        rdCount <= rdCount + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock monitor: done must be a single-cycle pulse held inside busy (R11)
  logic lastDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (done && lastDone) check(1'b0, "R11 done longer than one cycle", 1, 0);
      if (done && !busy)    check(1'b0, "R11 done without busy", 0, 1);
    end
    lastDone <= done;
  end

  task automatic poke(input int off, input logic [31:0] val);
    @(negedge clk);
    bdWe = 1'b1; bdAddr = 10'(off / 4); bdData = val;
    @(negedge clk);
    bdWe = 1'b0;
  endtask

  task automatic clearRam();
    @(negedge clk);
    bdClr = 1'b1;
    @(negedge clk);
    bdClr = 1'b0;
  endtask

  function automatic logic [31:0] hdr(input int nxt, input int ver, input int id);
    return {nxt[11:0], ver[3:0], id[15:0]};
  endfunction

  // behavioural reference built from the requirements
  function automatic void refRun(input bit app, input int id, input int ver,
                                 input int off, input int size,
                                 output int eOff, output int eP, output int eErr,
                                 output int eRd, output int eWr,
                                 output int eA1, output int eD1,
                                 output int eA2, output int eD2);
    int cur, prv, n, sid;
    logic [31:0] h;
    eOff = 0; eP = 0; eErr = 0; eRd = 0; eWr = 0;
    eA1 = -1; eD1 = 0; eA2 = -1; eD2 = 0;
    if (app && ((off % 4) != 0 || off < 256 || size < 8 || off + size >= 4096)) begin
      eErr = 1; return;
    end
    if (app && off == 256) begin
      h = mem[64];
      eRd = 1; eWr = 1; eA1 = 64; eD1 = {h[31:20], ver[3:0], id[15:0]};
      eOff = 256; return;
    end
    sid = app ? 0 : id;
    cur = 256; prv = 0; n = 0;
    while (1) begin
      h = mem[cur / 4];
      n++;
      if (n == 1 && h == 0) begin
        if (app) eErr = 1;
        break;
      end
      if (int'(h[15:0]) == sid) begin
        if (app) eErr = 1;
        else begin eOff = cur; eP = prv; end
        break;
      end
      if (h[31:20] == 0) begin
        if (app) begin
          eOff = off; eP = cur; eWr = 2;
          eA1 = cur / 4; eD1 = {off[11:0], h[19:0]};
          eA2 = off / 4; eD2 = {12'd0, ver[3:0], id[15:0]};
        end else begin
          eP = cur;
        end
        break;
      end
      if (h[21:20] != 0 || h[31:20] < 256 || h[31:20] > 4088 || n >= 960) begin
        eErr = 1; break;
      end
      prv = cur; cur = int'(h[31:20]);
    end
    eRd = n;
  endfunction

  task automatic runCmd(input string tag, input bit app, input int id, input int ver,
                        input int off, input int size, input int spurious);
    int eOff, eP, eErr, eRd, eWr, eA1, eD1, eA2, eD2;
    int r0, w0, n;
    refRun(app, id, ver, off, size, eOff, eP, eErr, eRd, eWr, eA1, eD1, eA2, eD2);
    @(negedge clk);
    r0 = rdCount; w0 = wrCount;
    cmdValid = 1'b1; cmdAppend = app; cmdId = 16'(id); cmdVer = 4'(ver);
    cmdOffset = 12'(off); cmdSize = 13'(size);
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b1, {tag, " R11 busy after accept"}, int'(busy), 1);
    if (spurious > 0) begin
      cmdValid = 1'b1; cmdId = 16'h7777; cmdAppend = 1'b1; cmdOffset = 12'h400; cmdSize = 13'd16;
      repeat (spurious) @(negedge clk);
      cmdValid = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done === 1'b1, {tag, " R11 done seen"}, int'(done), 1);
    check(resOffset == 12'(eOff), {tag, " offset"}, int'(resOffset), eOff);
    check(resPrev == 12'(eP), {tag, " prev"}, int'(resPrev), eP);
    check(resError == eErr[0], {tag, " error"}, int'(resError), eErr);
    check(rdCount - r0 == eRd, {tag, " R12 reads"}, rdCount - r0, eRd);
    check(wrCount - w0 == eWr, {tag, " writes"}, wrCount - w0, eWr);
    if (eA1 >= 0) check(mem[eA1] == eD1, {tag, " first word"}, int'(mem[eA1]), eD1);
    if (eA2 >= 0) check(mem[eA2] == eD2, {tag, " second word"}, int'(mem[eA2]), eD2);
    repeat (3) begin
      @(negedge clk);
      check(!done && !busy, {tag, " R11 idle after done"}, int'({done, busy}), 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !resError && !ramEn, "R1 outputs low in reset", int'({busy, done, resError, ramEn}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !ramEn && resOffset == 0 && resPrev == 0, "R1 idle after reset",
          int'({busy, done, ramEn}), 0);
    check(rdCount == 0 && wrCount == 0, "R1 no RAM access", rdCount + wrCount, 0);

    clearRam();
    runCmd("R2 empty chain find", 1'b0, 16'h0010, 0, 0, 0, 0);
    runCmd("R10 append to empty chain away from base", 1'b1, 16'h0021, 1, 'h200, 16, 0);

    poke('h100, hdr('h140, 1, 'h0003));
    poke('h140, hdr('h200, 2, 'h0010));
    poke('h200, hdr(0, 1, 'h000B));
    runCmd("R3 hit in middle", 1'b0, 'h0010, 0, 0, 0, 0);
    runCmd("R3 hit at head", 1'b0, 'h0003, 0, 0, 0, 0);
    runCmd("R3 hit at tail", 1'b0, 'h000B, 0, 0, 0, 0);
    runCmd("R4 miss reports tail", 1'b0, 'h0055, 0, 0, 0, 0);
    runCmd("R5 reserved id finds tail", 1'b0, 'h0000, 0, 0, 0, 0);
    runCmd("R11 busy ignores command", 1'b0, 'h000B, 0, 0, 0, 2);

    runCmd("R9 append at tail", 1'b1, 'h001A, 2, 'h300, 16, 0);
    runCmd("R9 new header found", 1'b0, 'h001A, 0, 0, 0, 0);
    runCmd("R8 append at base", 1'b1, 'h0001, 3, 'h100, 8, 0);
    runCmd("R8 chain intact", 1'b0, 'h001A, 0, 0, 0, 0);

    runCmd("R10 misaligned offset", 1'b1, 'h0002, 1, 'h302, 16, 0);
    runCmd("R10 offset below base", 1'b1, 'h0002, 1, 'h080, 16, 0);
    runCmd("R10 size too small", 1'b1, 'h0002, 1, 'h400, 4, 0);
    runCmd("R10 end reaches space top", 1'b1, 'h0002, 1, 'hFF8, 8, 0);
    runCmd("R10 end just below top", 1'b1, 'h0002, 1, 'hFF0, 8, 0);

    poke('hFF0, hdr('h202, 1, 'h0044));
    runCmd("R6 misaligned pointer", 1'b0, 'h0099, 0, 0, 0, 0);
    poke('hFF0, hdr('h040, 1, 'h0044));
    runCmd("R6 pointer below base", 1'b0, 'h0099, 0, 0, 0, 0);
    poke('hFF0, hdr('hFFC, 1, 'h0044));
    runCmd("R6 pointer above last header", 1'b0, 'h0099, 0, 0, 0, 0);

    clearRam();
    poke('h100, hdr('h100, 1, 'h0005));
    runCmd("R7 cyclic chain stops at limit", 1'b0, 'h0007, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule